// File: doc/BRIEF.md
# Telecom Bus Parity Generator and Checker

This block sits on a byte-wide SONET telecom bus that carries STS-1 or STS-3 traffic. On the transmit path it registers an outgoing data byte together with the payload-indicator and the C1/J1 marker. It then drives all of them out with a parity bit that covers exactly the values on the bus in that same cycle. On the receive path it latches the incoming byte, both markers and the received parity bit. It then recomputes parity over the latched values and raises a one-cycle error pulse on any mismatch.

An 8-bit control register holds the bus enable, the output tri-state request, the parity coverage choice, odd or even parity, and parity enable. It also holds two configuration bits, J1-only and rephase, that are stored and read back. A clear-on-read sticky error flag and a saturating error counter sit beside the control register on a small register port. Frame alignment and the detection of the C1/J1 position are done elsewhere; the markers arrive here as inputs.

Top module: `tbus_parity`

## Requirements
- R1: After reset the control register (address 0) reads 0x01, while status (address 1) and both counter bytes (addresses 2 and 3) read 0. Control bit 5 ignores writes and always reads 0; the other seven control bits read back as written. The control bits are: 7 bus enable, 6 tri-state, 4 coverage, 3 J1-only, 2 odd, 1 parity enable, 0 rephase.
- R2: The transmit data, payload-indicator and C1/J1 outputs show the inputs of the previous clock edge. The transmit parity output covers those same registered values in the same cycle.
- R3: With bus enable 1 and coverage 0, parity is computed over the 8 data bits only.
- R4: With bus enable 1 and coverage 1, parity is computed over the 8 data bits, the payload-indicator and the C1/J1 marker (10 bits).
- R5: With the odd bit at 0, the parity bit makes the count of ones in the covered bits plus parity even. With the odd bit at 1, it makes that count odd. This applies to both generation and checking.
- R6: With bus enable 0, the coverage bit acts as 0 and the tri-state bit has no effect, so the output enable stays 1.
- R7: With bus enable 1 and tri-state 1, the output enable (tx_oe_o) is 0; otherwise it is 1.
- R8: With parity enable 0, the transmit parity output is 0 and the error pulse stays low.
- R9: Receive inputs are latched on a clock edge. In the cycle that follows, the error pulse is 1 exactly when the latched parity bit differs from parity computed over the latched byte and markers under the current settings.
- R10: Each error pulse sets status bit 0, which is cleared by a read of address 1. A new error in the same cycle as that read keeps the bit set.
- R11: A 16-bit counter counts error pulses and holds at 0xFFFF. It is read as a low byte at address 2 and a high byte at address 3. Any write to address 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status on address 1) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| tx_data_i | input | 8 | Transmit byte in |
| tx_pl_i | input | 1 | Transmit payload-indicator in |
| tx_c1j1_i | input | 1 | Transmit C1/J1 marker in |
| tx_data_o | output | 8 | Registered transmit byte |
| tx_pl_o | output | 1 | Registered payload-indicator |
| tx_c1j1_o | output | 1 | Registered C1/J1 marker |
| tx_par_o | output | 1 | Transmit parity bit |
| tx_oe_o | output | 1 | Transmit output enable (0 = high impedance) |
| rx_data_i | input | 8 | Receive byte |
| rx_pl_i | input | 1 | Receive payload-indicator |
| rx_c1j1_i | input | 1 | Receive C1/J1 marker |
| rx_par_i | input | 1 | Received parity bit |
| rx_err_o | output | 1 | Parity error pulse |

## Verification
The sweep drives every data byte with all four marker combinations under each pairing of bus enable, coverage and odd parity. A parity that ignored the markers fails only in the enabled 10-bit cases. Disabled-bus runs set both coverage and tri-state, so any leak of those bits shows up. The receive parity bit is taken from a data-dependent function, so matches and mismatches both occur for every setting. Separate runs hold a known number of bad bytes to count the errors exactly, and run long enough to reach and hold counter saturation.

// File: rtl/tbus_pkg.sv
package tbus_pkg;
  typedef struct packed {
    logic bus_en;
    logic tristate;
    logic spare;
    logic cover_ctl;
    logic j1_only;
    logic odd;
    logic par_en;
    logic rephase;
  } tbus_ctrl_t;

  localparam logic [7:0] CTRL_RESET   = 8'h01;
  localparam logic [7:0] CTRL_WR_MASK = 8'hDF;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STAT   = 2'd1;
  localparam logic [1:0] ADDR_CNT_LO = 2'd2;
  localparam logic [1:0] ADDR_CNT_HI = 2'd3;
endpackage

// File: rtl/tbus_par_calc.sv
module tbus_par_calc #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              pl_i,
  input  logic              c1j1_i,
  input  logic              wide_i,
  input  logic              odd_i,
  output logic              par_o
);
  logic data_x;
  logic mark_x;

  assign data_x = ^data_i;
  assign mark_x = wide_i & (pl_i ^ c1j1_i);
  // even: parity equals xor of covered bits; odd: inverted
  assign par_o  = data_x ^ mark_x ^ odd_i;
endmodule

// File: rtl/tbus_regs.sv
module tbus_regs
  import tbus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       err_i,
  output logic       bus_en_o,
  output logic       tristate_o,
  output logic       cover_o,
  output logic       odd_o,
  output logic       par_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  tbus_ctrl_t       ctrl_q;
  logic             stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      cnt_ext;
  logic             cnt_clr;
  logic             stat_rd;

  assign cnt_clr = wr_i && (addr_i == ADDR_CNT_LO);
  assign stat_rd = rd_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= tbus_ctrl_t'(CTRL_RESET);
    else if (wr_i && addr_i == ADDR_CTRL) ctrl_q <= tbus_ctrl_t'(wdata_i & CTRL_WR_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_q <= 1'b0;
    else if (err_i)   stat_q <= 1'b1;
    else if (stat_rd) stat_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_clr)                 cnt_q <= '0;
    else if (err_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt_q;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:   rdata_o = ctrl_q;
      ADDR_STAT:   rdata_o = {7'd0, stat_q};
      ADDR_CNT_LO: rdata_o = cnt_ext[7:0];
      default:     rdata_o = cnt_ext[15:8];
    endcase
  end

  assign bus_en_o   = ctrl_q.bus_en;
  assign tristate_o = ctrl_q.tristate;
  assign cover_o    = ctrl_q.cover_ctl;
  assign odd_o      = ctrl_q.odd;
  assign par_en_o   = ctrl_q.par_en;

  a_r10_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_q);
  a_r11_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !cnt_clr) |=> cnt_q == CNT_MAX);
  a_r11_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/tbus_tx.sv
module tbus_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pl_i,
  input  logic              c1j1_i,
  input  logic              wide_i,
  input  logic              odd_i,
  input  logic              par_en_i,
  input  logic              bus_en_i,
  input  logic              tristate_i,
  output logic [DATA_W-1:0] data_o,
  output logic              pl_o,
  output logic              c1j1_o,
  output logic              par_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] data_q;
  logic              pl_q;
  logic              c1j1_q;
  logic              par_raw;
  logic              past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      pl_q      <= 1'b0;
      c1j1_q    <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      data_q    <= data_i;
      pl_q      <= pl_i;
      c1j1_q    <= c1j1_i;
      past_ok_q <= 1'b1;
    end
  end

  // parity from registered values keeps it aligned with the bus byte
  tbus_par_calc #(.DATA_W(DATA_W)) u_par (
    .data_i (data_q),
    .pl_i   (pl_q),
    .c1j1_i (c1j1_q),
    .wide_i (wide_i),
    .odd_i  (odd_i),
    .par_o  (par_raw)
  );

  assign data_o = data_q;
  assign pl_o   = pl_q;
  assign c1j1_o = c1j1_q;
  assign par_o  = par_en_i & par_raw;
  assign oe_o   = ~(bus_en_i & tristate_i);

  a_r2_data_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> data_o == $past(data_i));
  a_r2_mark_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (pl_o == $past(pl_i) && c1j1_o == $past(c1j1_i)));
endmodule

// File: rtl/tbus_rx.sv
module tbus_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pl_i,
  input  logic              c1j1_i,
  input  logic              par_i,
  input  logic              wide_i,
  input  logic              odd_i,
  input  logic              par_en_i,
  output logic              err_o
);
  logic [DATA_W-1:0] data_q;
  logic              pl_q;
  logic              c1j1_q;
  logic              par_q;
  logic              par_exp;
  logic              past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      pl_q      <= 1'b0;
      c1j1_q    <= 1'b0;
      par_q     <= 1'b0;
      past_ok_q <= 1'b0;
    end else begin
      data_q    <= data_i;
      pl_q      <= pl_i;
      c1j1_q    <= c1j1_i;
      par_q     <= par_i;
      past_ok_q <= 1'b1;
    end
  end

  tbus_par_calc #(.DATA_W(DATA_W)) u_par (
    .data_i (data_q),
    .pl_i   (pl_q),
    .c1j1_i (c1j1_q),
    .wide_i (wide_i),
    .odd_i  (odd_i),
    .par_o  (par_exp)
  );

  assign err_o = par_en_i & (par_exp ^ par_q);

  a_r9_par_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> (par_q == $past(par_i) && data_q == $past(data_i)));
endmodule

// File: rtl/tbus_parity.sv
module tbus_parity #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pl_i,
  input  logic              tx_c1j1_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_pl_o,
  output logic              tx_c1j1_o,
  output logic              tx_par_o,
  output logic              tx_oe_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pl_i,
  input  logic              rx_c1j1_i,
  input  logic              rx_par_i,
  output logic              rx_err_o
);
  logic bus_en, tristate, cover_ctl, odd, par_en, wide;

  tbus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (reg_addr_i),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .err_i      (rx_err_o),
    .bus_en_o   (bus_en),
    .tristate_o (tristate),
    .cover_o    (cover_ctl),
    .odd_o      (odd),
    .par_en_o   (par_en)
  );

  // coverage only counts while the bus is enabled
  assign wide = bus_en & cover_ctl;

  tbus_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (tx_data_i),
    .pl_i       (tx_pl_i),
    .c1j1_i     (tx_c1j1_i),
    .wide_i     (wide),
    .odd_i      (odd),
    .par_en_i   (par_en),
    .bus_en_i   (bus_en),
    .tristate_i (tristate),
    .data_o     (tx_data_o),
    .pl_o       (tx_pl_o),
    .c1j1_o     (tx_c1j1_o),
    .par_o      (tx_par_o),
    .oe_o       (tx_oe_o)
  );

  tbus_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (rx_data_i),
    .pl_i     (rx_pl_i),
    .c1j1_i   (rx_c1j1_i),
    .par_i    (rx_par_i),
    .wide_i   (wide),
    .odd_i    (odd),
    .par_en_i (par_en),
    .err_o    (rx_err_o)
  );

  a_r8_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_err_o || tx_par_o) |-> par_en);
endmodule

// File: tb/tbus_parity_tb.sv
module tbus_parity_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] tx_data = '0, tx_data_o;
  logic       tx_pl = 1'b0, tx_c1j1 = 1'b0;
  logic       tx_pl_o, tx_c1j1_o, tx_par_o, tx_oe_o;
  logic [7:0] rx_data = '0;
  logic       rx_pl = 1'b0, rx_c1j1 = 1'b0, rx_par = 1'b0, rx_err;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tbus_parity u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_data_i(tx_data), .tx_pl_i(tx_pl), .tx_c1j1_i(tx_c1j1),
    .tx_data_o(tx_data_o), .tx_pl_o(tx_pl_o), .tx_c1j1_o(tx_c1j1_o),
    .tx_par_o(tx_par_o), .tx_oe_o(tx_oe_o),
    .rx_data_i(rx_data), .rx_pl_i(rx_pl), .rx_c1j1_i(rx_c1j1),
    .rx_par_i(rx_par), .rx_err_o(rx_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic ref_par(input logic [7:0] d, input logic pl, input logic c1,
                                   input logic wide, input logic odd_p);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (wide) ones += pl + c1;
    return odd_p ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rx_set(input logic [7:0] d, input logic p);
    @(negedge clk); rx_data = d; rx_pl = 1'b0; rx_c1j1 = 1'b0; rx_par = p;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 tx data reset", tx_data_o, 0);
    check("R8 tx par reset", tx_par_o, 0);
    check("R9 err reset", rx_err, 0);
    rd(2'd0, v); check("R1 ctrl reset", v, 8'h01);
    rd(2'd1, v); check("R1 status reset", v, 0);
    rd(2'd2, v); check("R1 cnt lo reset", v, 0);
    rd(2'd3, v); check("R1 cnt hi reset", v, 0);
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R1 spare bit ignored", v, 8'hDF);
    wr(2'd0, 8'h20); rd(2'd0, v); check("R1 spare only", v, 8'h00);

    // R7 / R6 tri-state
    wr(2'd0, 8'hC2); #1 check("R7 oe off", tx_oe_o, 0);
    wr(2'd0, 8'h82); #1 check("R7 oe on", tx_oe_o, 1);
    wr(2'd0, 8'h42); #1 check("R6 tristate ignored", tx_oe_o, 1);

    // sweep: R2 R3 R4 R5 R6 on tx, R9 on rx
    for (int cfg = 0; cfg < 8; cfg++) begin
      logic be, cov, od;
      be = cfg[2]; cov = cfg[1]; od = cfg[0];
      wr(2'd0, {be, ~be, 1'b0, cov, 1'b0, od, 1'b1, 1'b0});
      for (int k = 0; k < 1024; k++) begin
        logic [7:0] d;
        logic pl, c1, rp, wide;
        d = k[7:0]; pl = k[8]; c1 = k[9];
        rp = d[0] ^ d[3] ^ pl;
        wide = be & cov;
        @(negedge clk);
        tx_data = d; tx_pl = pl; tx_c1j1 = c1;
        rx_data = d; rx_pl = pl; rx_c1j1 = c1; rx_par = rp;
        @(posedge clk); #5;
        check("R2 R3 R4 R5 R6 tx bus",
              {tx_oe_o, tx_par_o, tx_c1j1_o, tx_pl_o, tx_data_o},
              {1'b1, ref_par(d, pl, c1, wide, od), c1, pl, d});
        check("R9 R3 R4 R5 R6 rx err", rx_err, rp != ref_par(d, pl, c1, wide, od));
      end
    end

    // R8 parity disabled
    wr(2'd0, 8'h90);
    @(negedge clk); tx_data = 8'h01; rx_data = 8'h01; rx_pl = 1'b0; rx_c1j1 = 1'b0; rx_par = 1'b0;
    @(posedge clk); #5;
    check("R8 tx par off", tx_par_o, 0);
    check("R8 err off", rx_err, 0);

    // R10 / R11 exact count
    wr(2'd0, 8'h02);
    rx_set(8'h00, 1'b0);
    wr(2'd2, 8'h00);
    rd(2'd1, v);
    rd(2'd1, v); check("R10 status cleared by read", v, 0);
    for (int i = 0; i < 7; i++) rx_set(8'h00, 1'b1);
    rx_set(8'h00, 1'b0);
    repeat (2) @(negedge clk);
    rd(2'd2, v); check("R11 count lo", v, 7);
    rd(2'd3, v); check("R11 count hi", v, 0);
    rd(2'd1, v); check("R10 status set", v, 1);
    rd(2'd1, v); check("R10 status clear on read", v, 0);

    // R11 saturation
    for (int i = 0; i < 65540; i++) rx_set(8'h00, 1'b1);
    rx_set(8'h00, 1'b0);
    repeat (2) @(negedge clk);
    rd(2'd2, v); cnt[7:0] = v;
    rd(2'd3, v); cnt[15:8] = v;
    check("R11 saturated", cnt, 16'hFFFF);
    wr(2'd2, 8'h5A);
    rd(2'd2, v); cnt[7:0] = v;
    rd(2'd3, v); cnt[15:8] = v;
    check("R11 cleared", cnt, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule